// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the control state of one circular descriptor ring used by a DMA engine. In this scheme software and hardware exchange buffers through two kinds of ring. Software fills a free ring and hardware drains it. Hardware fills a used ring with descriptors it has finished, and software drains that ring. The block holds the ring's base address, its size, a producer pointer and a consumer pointer. From these it derives the occupancy, the spare room and four level events. The data movement itself, meaning the descriptor fetches and the bus master, lives outside the block.

Software programs the block through a small write port with a field select. Software always owns one of the two pointers. The base address, the ring size and the hardware-owned pointer can be written only while their bits in a gate field are set. The hardware side uses a request/acknowledge handshake. On a free ring it pops the descriptor at the consumer pointer. On a used ring it pushes into the slot at the producer pointer. In both cases the block returns that descriptor's byte address and advances the pointer on an acknowledged cycle.

The parameter `KIND` picks the flavour. It defaults to a free ring.

Top module: `dq_pointer_mgr`

## Requirements
- R1: Pointers are byte offsets in 32-byte slots: a written pointer value selects slot `value >> 5` (its low five bits are ignored), and `wr_off`/`rd_off` report the slot index times 32.
- R2: The ring size is the depth field value shifted right by 3. A depth write is accepted only when gate bit 1 is set and the resulting size is a power of two between 2 and `MAX_DESC`; any other depth write leaves the size unchanged.
- R3: The base address (select 0) is written only while gate bit 2 is set, and its low five bits are stored as zero. The hardware-owned pointer (select 3) is written only while gate bit 0 is set. The software-owned pointer (select 2) is always writable. The gate field is select 4, threshold low is select 5, threshold high is select 6, and depth is select 1.
- R4: Occupancy `occ_cnt` is (producer index − consumer index) mod size. `free_cnt` is size − 1 − occupancy, so one slot always stays unused.
- R5: On a free ring, `hw_ack` is high in the same cycle as `hw_req` whenever occupancy is non-zero. `hw_desc_addr` is base + 32 × consumer index, and the consumer pointer advances at the clock edge of an acknowledged cycle.
- R6: On a used ring, `hw_ack` is high with `hw_req` whenever occupancy is below size − 1. `hw_desc_addr` is base + 32 × producer index, and the producer pointer advances on an acknowledged cycle.
- R7: A hardware pointer advance wraps as (index + 1) AND (size − 1).
- R8: A refused request (pop on an empty free ring, push on a full used ring) gives `hw_ack` low and leaves both pointers unchanged.
- R9: `evt_empty` and `evt_full` are single-cycle pulses in the first cycle in which occupancy is 0, respectively size − 1.
- R10: `evt_low` pulses for one cycle when occupancy becomes ≤ threshold low. `evt_high` pulses for one cycle when occupancy becomes ≥ threshold high.
- R11: After reset, both pointers are 0, the base is 0, the size is `MAX_DESC`, threshold low is 0, threshold high is `MAX_DESC` − 1, the gate is 0, and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Field select of the write |
| cfg_wdata | input | 32 | Write data |
| hw_req | input | 1 | Hardware pop (free ring) or push (used ring) request |
| hw_ack | output | 1 | Request accepted this cycle |
| hw_desc_addr | output | 32 | Byte address of the descriptor at the hardware pointer |
| wr_off | output | 32 | Producer pointer as byte offset |
| rd_off | output | 32 | Consumer pointer as byte offset |
| occ_cnt | output | IDX_W+1 | Occupied slots |
| free_cnt | output | IDX_W+1 | Spare slots |
| evt_empty | output | 1 | Pulse: ring became empty |
| evt_full | output | 1 | Pulse: ring became full |
| evt_low | output | 1 | Pulse: occupancy fell to threshold low or below |
| evt_high | output | 1 | Pulse: occupancy rose to threshold high or above |

## Verification
The assertions that tie pointer motion to `hw_ack` assume that no configuration write lands in the same cycle as a hardware request, because a pointer write would override the advance. They also assume that software writes only valid sizes and in-range pointers when it expects the ring to behave. The bench keeps configuration writes and hardware requests in separate cycles. It programs small power-of-two sizes, and it offers the invalid depth only in order to check that the write is rejected. One free-ring instance and one used-ring instance are driven independently.

// File: rtl/dq_pkg.sv
package dq_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CFG_W = 32;

    typedef enum logic [0:0] {
        Q_FREE = 1'b0,
        Q_USED = 1'b1
    } q_kind_e;

    typedef enum logic [2:0] {
        SEL_BASE   = 3'd0,
        SEL_DEPTH  = 3'd1,
        SEL_SWPTR  = 3'd2,
        SEL_HWPTR  = 3'd3,
        SEL_GATE   = 3'd4,
        SEL_LOWTH  = 3'd5,
        SEL_HIGHTH = 3'd6
    } cfg_sel_e;

    // gate field bit positions
    localparam int GATE_HWPTR = 0;
    localparam int GATE_DEPTH = 1;
    localparam int GATE_BASE  = 2;

    typedef struct packed {
        logic empty;
        logic full;
        logic low;
        logic high;
    } lvl_flags_t;

    function automatic logic is_pow2(input logic [CFG_W-1:0] n);
        return (n != '0) && ((n & (n - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/dq_cfg_regs.sv
module dq_cfg_regs
    import dq_pkg::*;
#(
    parameter int MAX_DESC    = 1024,
    parameter int SLOT_SHIFT  = 5,
    parameter int DEPTH_SHIFT = 3,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] base_q,
    output logic [CNT_W-1:0] size_q,
    output logic [CNT_W-1:0] lo_th_q,
    output logic [CNT_W-1:0] hi_th_q,
    output logic             hwptr_open
);
    localparam logic [CFG_W-1:0] ALIGN_MASK = ~((CFG_W'(1) << SLOT_SHIFT) - CFG_W'(1));
    localparam logic [CFG_W-1:0] MAX_CNT    = CFG_W'(MAX_DESC);

    logic [2:0]       gate_q;
    logic [CFG_W-1:0] depth_cnt;
    logic             depth_ok;

    assign depth_cnt  = cfg_wdata >> DEPTH_SHIFT;
    assign depth_ok   = is_pow2(depth_cnt) && (depth_cnt >= CFG_W'(2)) && (depth_cnt <= MAX_CNT);
    assign hwptr_open = gate_q[GATE_HWPTR];

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= '0;
            base_q  <= '0;
            size_q  <= CNT_W'(MAX_DESC);
            lo_th_q <= '0;
            hi_th_q <= CNT_W'(MAX_DESC - 1);
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_GATE:   gate_q  <= cfg_wdata[2:0];
                SEL_LOWTH:  lo_th_q <= cfg_wdata[CNT_W-1:0];
                SEL_HIGHTH: hi_th_q <= cfg_wdata[CNT_W-1:0];
                SEL_BASE:   if (gate_q[GATE_BASE]) base_q <= cfg_wdata & ALIGN_MASK;
                SEL_DEPTH:  if (gate_q[GATE_DEPTH] && depth_ok) size_q <= depth_cnt[CNT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dq_ring_ptrs.sv
module dq_ring_ptrs
    import dq_pkg::*;
#(
    parameter q_kind_e KIND  = Q_FREE,
    parameter int      IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] mask,
    input  logic             sw_we,
    input  logic             hw_we,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic             hw_step,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] hw_idx
);
    logic [IDX_W-1:0] sw_q;
    logic [IDX_W-1:0] hw_q;
    logic [IDX_W-1:0] slot_in;

    assign slot_in = wr_slot & mask;

    always_ff @(posedge clk) begin
        if (rst)        sw_q <= '0;
        else if (sw_we) sw_q <= slot_in;
    end

    // a configuration write has priority over a hardware step
    always_ff @(posedge clk) begin
        if (rst)          hw_q <= '0;
        else if (hw_we)   hw_q <= slot_in;
        else if (hw_step) hw_q <= (hw_q + 1'b1) & mask;
    end

    assign hw_idx = hw_q;

    generate
        if (KIND == Q_FREE) begin : g_free
            assign wr_idx = sw_q;
            assign rd_idx = hw_q;
        end else begin : g_used
            assign wr_idx = hw_q;
            assign rd_idx = sw_q;
        end
    endgenerate
endmodule

// File: rtl/dq_level_mon.sv
module dq_level_mon
    import dq_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] mask,
    input  logic [CNT_W-1:0] size,
    input  logic [CNT_W-1:0] lo_th,
    input  logic [CNT_W-1:0] hi_th,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] spare,
    output lvl_flags_t       now,
    output lvl_flags_t       evt
);
    lvl_flags_t       prev_q;
    logic [IDX_W-1:0] diff;
    logic [CNT_W-1:0] top;

    assign diff  = (wr_idx - rd_idx) & mask;
    assign occ   = CNT_W'(diff);
    assign top   = size - 1'b1;
    assign spare = top - occ;

    assign now.empty = (occ == '0);
    assign now.full  = (occ == top);
    assign now.low   = (occ <= lo_th);
    assign now.high  = (occ >= hi_th);

    // all previous flags start set so reset itself raises no event
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= now;
    end

    assign evt = now & ~prev_q;
endmodule

// File: rtl/dq_pointer_mgr.sv
module dq_pointer_mgr
    import dq_pkg::*;
#(
    parameter q_kind_e KIND        = Q_FREE,
    parameter int      MAX_DESC    = 1024,
    parameter int      SLOT_BYTES  = 32,
    parameter int      DEPTH_SHIFT = 3,
    localparam int     IDX_W       = $clog2(MAX_DESC),
    localparam int     CNT_W       = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             hw_req,
    output logic             hw_ack,
    output logic [31:0]      hw_desc_addr,
    output logic [31:0]      wr_off,
    output logic [31:0]      rd_off,
    output logic [CNT_W-1:0] occ_cnt,
    output logic [CNT_W-1:0] free_cnt,
    output logic             evt_empty,
    output logic             evt_full,
    output logic             evt_low,
    output logic             evt_high
);
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    logic [31:0]      base_q;
    logic [CNT_W-1:0] size_q, lo_th_q, hi_th_q;
    logic             hwptr_open;
    logic [IDX_W-1:0] mask, wr_idx, rd_idx, hw_idx;
    logic             sw_we, hw_we, room;
    lvl_flags_t       now, evt;

    dq_cfg_regs #(
        .MAX_DESC(MAX_DESC), .SLOT_SHIFT(SLOT_SHIFT),
        .DEPTH_SHIFT(DEPTH_SHIFT), .CNT_W(CNT_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .size_q(size_q),
        .lo_th_q(lo_th_q), .hi_th_q(hi_th_q), .hwptr_open(hwptr_open)
    );

    assign mask  = IDX_W'(size_q - 1'b1);
    assign sw_we = cfg_we && (cfg_sel == SEL_SWPTR);
    assign hw_we = cfg_we && (cfg_sel == SEL_HWPTR) && hwptr_open;

    dq_ring_ptrs #(.KIND(KIND), .IDX_W(IDX_W)) u_ptrs (
        .clk(clk), .rst(rst), .mask(mask), .sw_we(sw_we), .hw_we(hw_we),
        .wr_slot(cfg_wdata[SLOT_SHIFT +: IDX_W]), .hw_step(hw_ack),
        .wr_idx(wr_idx), .rd_idx(rd_idx), .hw_idx(hw_idx)
    );

    dq_level_mon #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_lvl (
        .clk(clk), .rst(rst), .wr_idx(wr_idx), .rd_idx(rd_idx), .mask(mask),
        .size(size_q), .lo_th(lo_th_q), .hi_th(hi_th_q),
        .occ(occ_cnt), .spare(free_cnt), .now(now), .evt(evt)
    );

    generate
        if (KIND == Q_FREE) begin : g_pop
            assign room = !now.empty;
        end else begin : g_push
            assign room = !now.full;
        end
    endgenerate

    assign hw_ack       = hw_req && room;
    assign hw_desc_addr = base_q + (32'(hw_idx) << SLOT_SHIFT);
    assign wr_off       = 32'(wr_idx) << SLOT_SHIFT;
    assign rd_off       = 32'(rd_idx) << SLOT_SHIFT;

    assign evt_empty = evt.empty;
    assign evt_full  = evt.full;
    assign evt_low   = evt.low;
    assign evt_high  = evt.high;
endmodule

// File: rtl/dq_pointer_mgr_chk.sv
module dq_pointer_mgr_chk
    import dq_pkg::*;
#(
    parameter q_kind_e KIND  = Q_FREE,
    parameter int      CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             hw_req,
    input logic             hw_ack,
    input logic [31:0]      wr_off,
    input logic [31:0]      rd_off,
    input logic [CNT_W-1:0] occ_cnt,
    input logic [CNT_W-1:0] free_cnt,
    input logic             evt_empty,
    input logic             evt_full
);
    logic [31:0] hw_off;
    logic        has_room;

    assign hw_off   = (KIND == Q_FREE) ? rd_off : wr_off;
    assign has_room = (KIND == Q_FREE) ? (occ_cnt != '0) : (free_cnt != '0);

    assert_ack_has_room_R5: assert property (@(posedge clk) disable iff (rst)
        hw_ack |-> (hw_req && has_room));

    assert_ack_moves_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (hw_ack && !cfg_we) |=> !$stable(hw_off));

    assert_refused_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (hw_req && !hw_ack && !cfg_we) |=> ($stable(wr_off) && $stable(rd_off)));

    assert_empty_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        evt_empty |=> !evt_empty);

    assert_full_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        evt_full |=> !evt_full);

    assert_empty_level_R4: assert property (@(posedge clk) disable iff (rst)
        evt_empty |-> (occ_cnt == '0));

    assert_full_level_R4: assert property (@(posedge clk) disable iff (rst)
        evt_full |-> (free_cnt == '0));
endmodule

bind dq_pointer_mgr dq_pointer_mgr_chk #(.KIND(KIND), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .hw_req(hw_req), .hw_ack(hw_ack),
    .wr_off(wr_off), .rd_off(rd_off), .occ_cnt(occ_cnt), .free_cnt(free_cnt),
    .evt_empty(evt_empty), .evt_full(evt_full)
);

// File: tb/dq_pointer_mgr_test.sv
module dq_pointer_mgr_test;
    import dq_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // free-ring instance
    logic          f_we = 1'b0, f_req = 1'b0, f_ack;
    logic [2:0]    f_sel = '0;
    logic [31:0]   f_wd = '0, f_addr, f_wr, f_rd;
    logic [CW-1:0] f_occ, f_free;
    logic          f_ee, f_ef, f_el, f_eh;

    // used-ring instance
    logic          u_we = 1'b0, u_req = 1'b0, u_ack;
    logic [2:0]    u_sel = '0;
    logic [31:0]   u_wd = '0, u_addr, u_wr, u_rd;
    logic [CW-1:0] u_occ, u_free;
    logic          u_ee, u_ef, u_el, u_eh;

    int total = 0;
    int bad   = 0;

    dq_pointer_mgr #(.KIND(Q_FREE)) uut (
        .clk(clk), .rst(rst), .cfg_we(f_we), .cfg_sel(f_sel), .cfg_wdata(f_wd),
        .hw_req(f_req), .hw_ack(f_ack), .hw_desc_addr(f_addr),
        .wr_off(f_wr), .rd_off(f_rd), .occ_cnt(f_occ), .free_cnt(f_free),
        .evt_empty(f_ee), .evt_full(f_ef), .evt_low(f_el), .evt_high(f_eh)
    );

    dq_pointer_mgr #(.KIND(Q_USED)) uut_used (
        .clk(clk), .rst(rst), .cfg_we(u_we), .cfg_sel(u_sel), .cfg_wdata(u_wd),
        .hw_req(u_req), .hw_ack(u_ack), .hw_desc_addr(u_addr),
        .wr_off(u_wr), .rd_off(u_rd), .occ_cnt(u_occ), .free_cnt(u_free),
        .evt_empty(u_ee), .evt_full(u_ef), .evt_low(u_el), .evt_high(u_eh)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic f_cfg(input cfg_sel_e sel, input logic [31:0] d);
        @(negedge clk);
        f_we = 1'b1; f_sel = sel; f_wd = d;
        @(negedge clk);
        f_we = 1'b0;
    endtask

    task automatic u_cfg(input cfg_sel_e sel, input logic [31:0] d);
        @(negedge clk);
        u_we = 1'b1; u_sel = sel; u_wd = d;
        @(negedge clk);
        u_we = 1'b0;
    endtask

    task automatic f_pop(output logic ack, output logic [31:0] addr);
        @(negedge clk);
        f_req = 1'b1;
        #1;
        ack = f_ack; addr = f_addr;
        @(negedge clk);
        f_req = 1'b0;
    endtask

    task automatic u_push(output logic ack, output logic [31:0] addr);
        @(negedge clk);
        u_req = 1'b1;
        #1;
        ack = u_ack; addr = u_addr;
        @(negedge clk);
        u_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 wr_off", f_wr, 0);
        chk("R11 rd_off", f_rd, 0);
        chk("R11 occ", 32'(f_occ), 0);
        chk("R11 free=MAX-1", 32'(f_free), 1023);
        chk("R11 no events", {28'd0, f_ee, f_ef, f_el, f_eh}, 0);
        chk("R11 base zero", f_addr, 0);
    endtask

    task automatic t_gating;
        f_cfg(SEL_BASE, 32'h1000_0013);
        chk("R3 base write gated off", f_addr, 0);
        f_cfg(SEL_GATE, 32'h4);
        f_cfg(SEL_BASE, 32'h1000_0013);
        chk("R3 base aligned", f_addr, 32'h1000_0000);
        f_cfg(SEL_DEPTH, 32'd64);
        chk("R2 depth gated off", 32'(f_free), 1023);
        f_cfg(SEL_GATE, 32'h2);
        f_cfg(SEL_DEPTH, 32'd64);
        chk("R2 size 8", 32'(f_free), 7);
        f_cfg(SEL_DEPTH, 32'd48);
        chk("R2 non-pow2 depth ignored", 32'(f_free), 7);
        f_cfg(SEL_GATE, 32'h0);
        f_cfg(SEL_LOWTH, 32'd2);
        f_cfg(SEL_HIGHTH, 32'd6);
    endtask

    task automatic t_drain;
        logic a; logic [31:0] ad;
        f_cfg(SEL_SWPTR, 32'd96 + 32'd7);
        chk("R1 wr_off low bits dropped", f_wr, 96);
        chk("R4 occ 3", 32'(f_occ), 3);
        chk("R4 free 4", 32'(f_free), 4);
        f_pop(a, ad);
        chk("R5 pop ack", 32'(a), 1);
        chk("R5 pop addr", ad, 32'h1000_0000);
        chk("R10 low pulse at occ 2", 32'(f_el), 1);
        f_pop(a, ad);
        chk("R5 pop addr 2", ad, 32'h1000_0020);
        f_pop(a, ad);
        chk("R5 pop addr 3", ad, 32'h1000_0040);
        chk("R9 empty pulse", 32'(f_ee), 1);
        f_pop(a, ad);
        chk("R8 empty pop refused", 32'(a), 0);
        chk("R8 rd unchanged", f_rd, 96);
        chk("R9 empty pulse single", 32'(f_ee), 0);
    endtask

    task automatic t_wrap;
        logic a; logic [31:0] ad;
        f_cfg(SEL_SWPTR, 32'd224);
        chk("R4 occ 4", 32'(f_occ), 4);
        for (int i = 0; i < 4; i++) f_pop(a, ad);
        chk("R5 rd at 7", f_rd, 224);
        f_cfg(SEL_SWPTR, 32'd32);
        chk("R4 occ across wrap", 32'(f_occ), 2);
        f_pop(a, ad);
        chk("R5 addr slot 7", ad, 32'h1000_00E0);
        chk("R7 rd wraps to 0", f_rd, 0);
        f_pop(a, ad);
        chk("R7 rd after wrap", f_rd, 32);
    endtask

    task automatic t_full;
        f_cfg(SEL_SWPTR, 32'd0);
        chk("R4 occ 7", 32'(f_occ), 7);
        chk("R4 free 0", 32'(f_free), 0);
        chk("R9 full pulse", 32'(f_ef), 1);
        chk("R10 high pulse", 32'(f_eh), 1);
        @(negedge clk);
        chk("R9 full pulse single", 32'(f_ef), 0);
        chk("R10 high pulse single", 32'(f_eh), 0);
    endtask

    task automatic t_hwptr;
        logic a; logic [31:0] ad;
        f_cfg(SEL_HWPTR, 32'd96);
        chk("R3 hw ptr gated off", f_rd, 32);
        f_cfg(SEL_GATE, 32'h1);
        f_cfg(SEL_HWPTR, 32'd96);
        chk("R3 hw ptr written", f_rd, 96);
        chk("R4 occ 5", 32'(f_occ), 5);
        f_pop(a, ad);
        chk("R10 no low at 4", 32'(f_el), 0);
        f_pop(a, ad);
        f_pop(a, ad);
        chk("R5 addr slot 5", ad, 32'h1000_00A0);
        chk("R10 low pulse again", 32'(f_el), 1);
    endtask

    task automatic t_used;
        logic a; logic [31:0] ad;
        u_cfg(SEL_GATE, 32'h2);
        u_cfg(SEL_DEPTH, 32'd32);
        chk("R2 used size 4", 32'(u_free), 3);
        u_push(a, ad);
        chk("R6 push ack", 32'(a), 1);
        chk("R6 push addr 0", ad, 0);
        u_push(a, ad);
        chk("R6 push addr 1", ad, 32'h20);
        u_push(a, ad);
        chk("R6 push addr 2", ad, 32'h40);
        chk("R9 used full pulse", 32'(u_ef), 1);
        u_push(a, ad);
        chk("R8 full push refused", 32'(a), 0);
        chk("R8 wr unchanged", u_wr, 96);
        u_cfg(SEL_SWPTR, 32'd64);
        chk("R4 used occ 1", 32'(u_occ), 1);
        chk("R4 used free 2", 32'(u_free), 2);
        u_push(a, ad);
        chk("R6 push addr 3", ad, 32'h60);
        chk("R7 used wr wraps", u_wr, 0);
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gating();
        t_drain();
        t_wrap();
        t_full();
        t_hwptr();
        t_used();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule